// File: doc/BRIEF.md
# Controller Power-Up Initialization Sequencer

This block takes a multichannel HDLC controller from reset to a state where it can carry packets. After a start pulse it issues a fixed, ordered series of register writes over a simple memory-mapped write port. The port has an address, write data, a write strobe and a ready return. The series has three parts.

- Clear: the block issues a master software reset, zeroes every entry of a parameter-defined list of indirect register groups, and issues a second software reset.
- Configure: it programs the port mode with every enable still off.
- Enable: it turns functions on in a fixed order. Descriptor loading is handed to an external agent through a request/done handshake. Port transmit is enabled last.

The bridge-mode register is written first, and only when the bridge strap is high. A software reset does not clear that register, so writing it before the resets is safe. When the high-speed strap is high, the port is first set up as low-speed unchannelized. It is switched to high speed in the same write that enables transmit.

After the final enable the block waits for both bounds to expire: a number of ticks from a free-running microsecond tick, and a number of clock cycles. Only then does it raise ready. A bus write that stays unacknowledged beyond a programmable number of cycles stops the sequence with an error. A new start pulse restarts it from the beginning.

Top module: `hdlc_boot_seq`

## Requirements
- R1: After reset, and until a start pulse, busWr, descReq, ready and error are all low.
- R2: When bridgeStrap is high, the first write of a run is address 0x0010 with data BRIDGE_CFG (default 0x0001). When bridgeStrap is low, no write goes to 0x0010.
- R3: A software reset is the write 0x0001 to address 0x0000. It is issued once before and once after the indirect clear. When bridgeStrap is low, it is the first write of the run.
- R4: The indirect clear writes data 0 to address GROUP_BASE[g]+i. Groups go in list order g = 0..NUM_GROUPS-1, and within each group the index goes upward i = 0..GROUP_SIZE[g]-1. All group addresses are at or above 0x1000.
- R5: While busWr is high and busRdy is low, busAddr and busData hold steady. Each write is accepted on exactly one clock edge where busWr and busRdy are both high.
- R6: The port-mode write during configuration goes to 0x0020. In it, bit 0 (transmit enable) is 0, bit 2 (high speed) is 0, and bit 1 (unchannelized) equals hsStrap.
- R7: After the port-mode write, the writes come in this order:
  - channel enable: 0x0003 to 0x0030;
  - descriptor handshake;
  - global receive/transmit DMA enable: 0x0003 to 0x0040;
  - per-channel DMA enable: 0x0001 to 0x0050;
  - port enable to 0x0020, with bit 0 = 1 and bits 1 and 2 both equal to hsStrap.

  No write with port bit 0 set comes before the per-channel DMA enable.
- R8: descReq is held high, with no bus write, from the channel-enable write until a descDone pulse.
- R9: ready rises only after the final port write has been followed by at least SETTLE_CYCLES clock cycles and at least SETTLE_US usTick pulses. It rises within a few cycles of the later of those two bounds.
- R10: A start pulse while a run is in progress has no effect: the write series of that run is unchanged.
- R11: If busRdy stays low for TIMEOUT cycles of a pending write, error goes high and busWr, descReq and ready go low. A later start pulse clears error and runs the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the line clock counted by the settle wait |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts the sequence |
| bridgeStrap | input | 1 | High when the controller sits behind a local-bus bridge |
| hsStrap | input | 1 | High for high-speed unchannelized port mode |
| usTick | input | 1 | One-cycle pulse every microsecond |
| descDone | input | 1 | Pulse from the agent that has loaded the DMA descriptors |
| busRdy | input | 1 | Write accepted by the register port |
| busAddr | output | 16 | Write address |
| busData | output | 16 | Write data |
| busWr | output | 1 | Write strobe, held until busRdy |
| descReq | output | 1 | Request to load descriptors |
| ready | output | 1 | Controller may now carry packets |
| error | output | 1 | Bus write timed out; sequence stopped |

## Verification
The bound checker watches these rules on every cycle:
- a pending write stays stable;
- no write is issued during the descriptor handshake;
- every write into the indirect range carries zero data;
- no port transmit enable appears before the per-channel DMA enable;
- ready never rises before both settle bounds have passed since the final port write;
- error always silences the bus.

Only the bench's scenarios can show the full order and content of the write series. That covers both strap settings, the exact walk through each group's index range, a start pulse ignored mid-run, whether the settle time is bounded by ticks or by cycles, and recovery from a timeout.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_SWRST  = 16'h0000;
  localparam logic [ADDR_W-1:0] ADDR_BRIDGE = 16'h0010;
  localparam logic [ADDR_W-1:0] ADDR_PORT   = 16'h0020;
  localparam logic [ADDR_W-1:0] ADDR_CHAN   = 16'h0030;
  localparam logic [ADDR_W-1:0] ADDR_DMA    = 16'h0040;
  localparam logic [ADDR_W-1:0] ADDR_CHDMA  = 16'h0050;
  localparam logic [ADDR_W-1:0] CLR_FLOOR   = 16'h1000;

  localparam logic [DATA_W-1:0] DATA_SWRST  = 16'h0001;
  localparam logic [DATA_W-1:0] DATA_CHAN   = 16'h0003;
  localparam logic [DATA_W-1:0] DATA_DMA    = 16'h0003;
  localparam logic [DATA_W-1:0] DATA_CHDMA  = 16'h0001;

  typedef enum logic [2:0] {
    SEL_SWRST, SEL_BRIDGE, SEL_PORTCFG, SEL_PORTON,
    SEL_CHAN, SEL_DMA, SEL_CHDMA, SEL_CLEAR
  } wr_sel_e;

  typedef struct packed {
    wr_sel_e sel;
    logic    idxClr;
    logic    idxInc;
    logic    grpInc;
    logic    settleClr;
    logic    settleRun;
  } seq_ctrl_t;

  typedef struct packed {
    logic idxLast;
    logic grpLast;
    logic settleDone;
    logic timedOut;
  } seq_stat_t;
endpackage

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 11,
  parameter int unsigned IDX_W = 16,
  parameter logic [ADDR_W-1:0] GROUP_BASE [NUM_GROUPS] = '{default: '0},
  parameter logic [IDX_W-1:0]  GROUP_SIZE [NUM_GROUPS] = '{default: 16'd1},
  parameter logic [DATA_W-1:0] BRIDGE_CFG = 16'h0001,
  parameter int unsigned SETTLE_US = 500,
  parameter int unsigned SETTLE_CYCLES = 768,
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctrl_t         ctrl,
  input  logic              usTick,
  input  logic              hsStrap,
  input  logic              busWr,
  input  logic              busRdy,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output seq_stat_t         stat
);
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int CYC_W = $clog2(SETTLE_CYCLES + 1);
  localparam int US_W  = $clog2(SETTLE_US + 1);
  localparam int TO_W  = $clog2(TIMEOUT + 1);

  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  logic [CYC_W-1:0] cycCnt;
  logic [US_W-1:0]  usCnt;
  logic [TO_W-1:0]  toCnt;
  logic             waiting;

  assign waiting = busWr && !busRdy;

  // group / index walker for the indirect clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grp <= '0;
      idx <= '0;
    end else if (ctrl.idxClr) begin
      grp <= '0;
      idx <= '0;
    end else if (ctrl.grpInc) begin
      grp <= grp + 1'b1;
      idx <= '0;
    end else if (ctrl.idxInc) begin
      idx <= idx + 1'b1;
    end
  end

  // settle timer: cycle bound and microsecond bound run side by side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      usCnt  <= '0;
    end else if (ctrl.settleClr) begin
      cycCnt <= '0;
      usCnt  <= '0;
    end else if (ctrl.settleRun) begin
      if (cycCnt != CYC_W'(SETTLE_CYCLES)) cycCnt <= cycCnt + 1'b1;
      if (usTick && usCnt != US_W'(SETTLE_US)) usCnt <= usCnt + 1'b1;
    end
  end

  // bus handshake watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) toCnt <= '0;
    else if (waiting) toCnt <= toCnt + 1'b1;
    else toCnt <= '0;
  end

  assign stat.idxLast    = (idx == GROUP_SIZE[grp] - 1'b1);
  assign stat.grpLast    = (grp == GRP_W'(NUM_GROUPS - 1));
  assign stat.settleDone = (cycCnt == CYC_W'(SETTLE_CYCLES)) && (usCnt == US_W'(SETTLE_US));
  assign stat.timedOut   = waiting && (toCnt == TO_W'(TIMEOUT - 1));

  always_comb begin
    busAddr = ADDR_SWRST;
    busData = DATA_SWRST;
    case (ctrl.sel)
      SEL_SWRST:   begin busAddr = ADDR_SWRST;  busData = DATA_SWRST; end
      SEL_BRIDGE:  begin busAddr = ADDR_BRIDGE; busData = BRIDGE_CFG; end
      SEL_PORTCFG: begin busAddr = ADDR_PORT;   busData = DATA_W'({hsStrap, 1'b0}); end
      SEL_PORTON:  begin busAddr = ADDR_PORT;   busData = DATA_W'({hsStrap, hsStrap, 1'b1}); end
      SEL_CHAN:    begin busAddr = ADDR_CHAN;   busData = DATA_CHAN; end
      SEL_DMA:     begin busAddr = ADDR_DMA;    busData = DATA_DMA; end
      SEL_CHDMA:   begin busAddr = ADDR_CHDMA;  busData = DATA_CHDMA; end
      SEL_CLEAR:   begin busAddr = GROUP_BASE[grp] + ADDR_W'(idx); busData = '0; end
      default:     begin busAddr = ADDR_SWRST;  busData = DATA_SWRST; end
    endcase
  end
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      bridgeStrap,
  input  logic      descDone,
  input  logic      busRdy,
  input  seq_stat_t stat,
  output seq_ctrl_t ctrl,
  output logic      busWr,
  output logic      descReq,
  output logic      ready,
  output logic      error
);
  typedef enum logic [3:0] {
    S_IDLE, S_BRIDGE, S_RST1, S_CLEAR, S_RST2, S_PORTCFG, S_CHANEN,
    S_DESC, S_DMAEN, S_CHDMA, S_PORTON, S_SETTLE, S_READY, S_FAULT
  } state_e;

  state_e state, nxt, after;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else state <= nxt;
  end

  always_comb begin
    nxt   = state;
    after = state;
    ctrl  = '0;
    busWr = 1'b0;
    case (state)
      S_IDLE, S_READY, S_FAULT:
        if (start) begin
          ctrl.idxClr = 1'b1;
          nxt = bridgeStrap ? S_BRIDGE : S_RST1;
        end
      S_BRIDGE:  begin busWr = 1'b1; ctrl.sel = SEL_BRIDGE;  after = S_RST1; end
      S_RST1:    begin busWr = 1'b1; ctrl.sel = SEL_SWRST;   after = S_CLEAR; end
      S_CLEAR: begin
        busWr    = 1'b1;
        ctrl.sel = SEL_CLEAR;
        after    = (stat.idxLast && stat.grpLast) ? S_RST2 : S_CLEAR;
        if (busRdy) begin
          ctrl.grpInc = stat.idxLast && !stat.grpLast;
          ctrl.idxInc = !stat.idxLast;
        end
      end
      S_RST2:    begin busWr = 1'b1; ctrl.sel = SEL_SWRST;   after = S_PORTCFG; end
      S_PORTCFG: begin busWr = 1'b1; ctrl.sel = SEL_PORTCFG; after = S_CHANEN; end
      S_CHANEN:  begin busWr = 1'b1; ctrl.sel = SEL_CHAN;    after = S_DESC; end
      S_DESC:    if (descDone) nxt = S_DMAEN;
      S_DMAEN:   begin busWr = 1'b1; ctrl.sel = SEL_DMA;     after = S_CHDMA; end
      S_CHDMA:   begin busWr = 1'b1; ctrl.sel = SEL_CHDMA;   after = S_PORTON; end
      S_PORTON: begin
        busWr          = 1'b1;
        ctrl.sel       = SEL_PORTON;
        after          = S_SETTLE;
        ctrl.settleClr = busRdy;
      end
      S_SETTLE: begin
        ctrl.settleRun = 1'b1;
        if (stat.settleDone) nxt = S_READY;
      end
      default: nxt = S_IDLE;
    endcase
    if (busWr) begin
      if (busRdy) nxt = after;
      else if (stat.timedOut) nxt = S_FAULT;
    end
  end

  assign descReq = (state == S_DESC);
  assign ready   = (state == S_READY);
  assign error   = (state == S_FAULT);
endmodule

// File: rtl/hdlc_boot_seq.sv
module hdlc_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 11,
  parameter int unsigned IDX_W = 16,
  parameter logic [ADDR_W-1:0] GROUP_BASE [NUM_GROUPS] = '{
    16'h4000, 16'h5800, 16'h5900, 16'h6000, 16'h6800, 16'h7400,
    16'h7800, 16'h7C00, 16'h7D00, 16'h8000, 16'h8400},
  parameter logic [IDX_W-1:0] GROUP_SIZE [NUM_GROUPS] = '{
    16'd6144, 16'd256, 16'd256, 16'd1536, 16'd3072, 16'd256,
    16'd1024, 16'd256, 16'd256, 16'd1024, 16'd256},
  parameter logic [DATA_W-1:0] BRIDGE_CFG = 16'h0001,
  parameter int unsigned SETTLE_US = 500,
  parameter int unsigned SETTLE_CYCLES = 768,
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              bridgeStrap,
  input  logic              hsStrap,
  input  logic              usTick,
  input  logic              descDone,
  input  logic              busRdy,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              busWr,
  output logic              descReq,
  output logic              ready,
  output logic              error
);
  seq_ctrl_t ctrl;
  seq_stat_t stat;

  boot_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bridgeStrap(bridgeStrap),
    .descDone(descDone), .busRdy(busRdy), .stat(stat), .ctrl(ctrl),
    .busWr(busWr), .descReq(descReq), .ready(ready), .error(error)
  );

  boot_seq_dp #(
    .NUM_GROUPS(NUM_GROUPS), .IDX_W(IDX_W), .GROUP_BASE(GROUP_BASE),
    .GROUP_SIZE(GROUP_SIZE), .BRIDGE_CFG(BRIDGE_CFG), .SETTLE_US(SETTLE_US),
    .SETTLE_CYCLES(SETTLE_CYCLES), .TIMEOUT(TIMEOUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .usTick(usTick), .hsStrap(hsStrap),
    .busWr(busWr), .busRdy(busRdy), .busAddr(busAddr), .busData(busData),
    .stat(stat)
  );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
  import boot_seq_pkg::*;
#(
  parameter int unsigned SETTLE_US = 500,
  parameter int unsigned SETTLE_CYCLES = 768
) (
  input logic              clk,
  input logic              rstN,
  input logic              usTick,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              busWr,
  input logic              busRdy,
  input logic              descReq,
  input logic              ready,
  input logic              error
);
  localparam int CYC_W = $clog2(SETTLE_CYCLES + 1);
  localparam int US_W  = $clog2(SETTLE_US + 1);

  logic             dmaSeen;
  logic [CYC_W-1:0] cycSince;
  logic [US_W-1:0]  tickSince;
  logic             accept;

  assign accept = busWr && busRdy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaSeen   <= 1'b0;
      cycSince  <= '0;
      tickSince <= '0;
    end else begin
      if (accept && busAddr == ADDR_SWRST) dmaSeen <= 1'b0;
      else if (accept && busAddr == ADDR_CHDMA) dmaSeen <= 1'b1;
      if (accept && busAddr == ADDR_PORT && busData[0]) begin
        cycSince  <= '0;
        tickSince <= '0;
      end else begin
        if (cycSince != CYC_W'(SETTLE_CYCLES)) cycSince <= cycSince + 1'b1;
        if (usTick && tickSince != US_W'(SETTLE_US)) tickSince <= tickSince + 1'b1;
      end
    end
  end

  // R5: pending write holds steady until accepted (or the timeout fault)
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !busRdy |=> error || (busWr && $stable(busAddr) && $stable(busData)));

  // R8: no bus traffic during descriptor handshake
  p_desc_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    descReq |-> !busWr);

  // R4: indirect range only ever receives zero
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr >= CLR_FLOOR |-> busData == '0);

  // R6: configuration-time port write keeps transmit off
  p_port_muted_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_PORT && !dmaSeen |-> !busData[0]);

  // R7: port transmit enable only after per-channel DMA enable
  p_port_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_PORT && busData[0] |-> dmaSeen);

  // R9: ready waits out both settle bounds
  p_settle_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> cycSince == CYC_W'(SETTLE_CYCLES) && tickSince == US_W'(SETTLE_US));

  // R11: a fault silences everything
  p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !busWr && !ready && !descReq);
endmodule

bind hdlc_boot_seq boot_seq_chk #(
  .SETTLE_US(SETTLE_US), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .usTick(usTick), .busAddr(busAddr),
  .busData(busData), .busWr(busWr), .busRdy(busRdy), .descReq(descReq),
  .ready(ready), .error(error)
);

// File: tb/hdlc_boot_seq_bench.sv
module hdlc_boot_seq_bench;
  localparam int NG = 3;
  localparam logic [15:0] GB [NG] = '{16'h4000, 16'h5000, 16'h6000};
  localparam logic [15:0] GS [NG] = '{16'd4, 16'd2, 16'd3};
  localparam int SUS = 20;
  localparam int SCYC = 50;
  localparam int TO = 16;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, bridgeStrap = 1'b0, hsStrap = 1'b0;
  logic usTick = 1'b0, descDone = 1'b0, busRdy = 1'b0;
  logic [15:0] busAddr, busData;
  logic busWr, descReq, ready, error;

  hdlc_boot_seq #(
    .NUM_GROUPS(NG), .GROUP_BASE(GB), .GROUP_SIZE(GS),
    .SETTLE_US(SUS), .SETTLE_CYCLES(SCYC), .TIMEOUT(TO)
  ) u_hdlc_boot_seq (
    .clk(clk), .rstN(rstN), .start(start), .bridgeStrap(bridgeStrap),
    .hsStrap(hsStrap), .usTick(usTick), .descDone(descDone), .busRdy(busRdy),
    .busAddr(busAddr), .busData(busData), .busWr(busWr), .descReq(descReq),
    .ready(ready), .error(error)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, tickTotal = 0, tickPer = 1, phase = 0;
  int rdyDelay = 0, waitCnt = 0;
  bit stall = 1'b0;
  int logN = 0, onCyc = 0, onTicks = 0, stabErr = 0;
  logic [15:0] logA [64], logD [64];
  bit prevWait = 1'b0;
  logic [15:0] pA = '0, pD = '0;
  bit done = 1'b0;

  // tick source, bus responder, write logger
  always @(posedge clk) begin
    cyc++;
    if (usTick) tickTotal++;
    if (busWr && busRdy) begin
      if (logN < 64) begin
        logA[logN] = busAddr;
        logD[logN] = busData;
      end
      logN++;
      if (busAddr == 16'h0020 && busData[0]) begin
        onCyc = cyc;
        onTicks = tickTotal;
      end
    end
    if (prevWait && busWr && (busAddr != pA || busData != pD)) stabErr++;
    prevWait = busWr && !busRdy;
    pA = busAddr;
    pD = busData;
    busRdy <= !stall && busWr && !busRdy && (waitCnt >= rdyDelay);
    waitCnt <= (busWr && !busRdy) ? waitCnt + 1 : 0;
    usTick <= (tickPer == 1) ? 1'b1 : (phase == tickPer - 1);
    phase <= (phase >= tickPer - 1) ? 0 : phase + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busWr && !descReq && !ready && !error, "R1", "outputs in reset",
        {busWr, descReq, ready, error}, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busWr && !descReq && !ready && !error, "R1", "outputs idle after reset",
        {busWr, descReq, ready, error}, 0);
    chk(logN == 0, "R1", "writes before start", logN, 0);
  endtask

  task automatic runSeq(input bit bridge, input bit hs, input int delay,
                        input int tickP, input bit poke);
    logic [15:0] eA [64], eD [64];
    string eT [64];
    int n = 0, lim, snap, elapsed, ticks, upper;
    @(negedge clk);
    bridgeStrap = bridge; hsStrap = hs; rdyDelay = delay; tickPer = tickP;
    logN = 0;
    if (bridge) begin eA[n] = 16'h0010; eD[n] = 16'h0001; eT[n] = "R2"; n++; end
    eA[n] = 16'h0000; eD[n] = 16'h0001; eT[n] = "R3"; n++;
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < int'(GS[g]); i++) begin
        eA[n] = GB[g] + 16'(i); eD[n] = 16'h0000; eT[n] = "R4"; n++;
      end
    eA[n] = 16'h0000; eD[n] = 16'h0001; eT[n] = "R3"; n++;
    eA[n] = 16'h0020; eD[n] = hs ? 16'h0002 : 16'h0000; eT[n] = "R6"; n++;
    eA[n] = 16'h0030; eD[n] = 16'h0003; eT[n] = "R7"; n++;
    eA[n] = 16'h0040; eD[n] = 16'h0003; eT[n] = "R7"; n++;
    eA[n] = 16'h0050; eD[n] = 16'h0001; eT[n] = "R7"; n++;
    eA[n] = 16'h0020; eD[n] = hs ? 16'h0007 : 16'h0001; eT[n] = "R7"; n++;
    pulseStart();
    lim = 0;
    while (!descReq && lim < 3000) begin @(negedge clk); lim++; end
    chk(descReq, "R8", "descReq raised", descReq, 1);
    snap = logN;
    if (poke) pulseStart();
    repeat (6) @(negedge clk);
    chk(logN == snap && descReq, "R8", "quiet while waiting for descDone",
        logN, snap);
    descDone = 1'b1;
    @(negedge clk) descDone = 1'b0;
    lim = 0;
    while (!ready && lim < 3000) begin @(negedge clk); lim++; end
    chk(ready, "R9", "ready raised", ready, 1);
    elapsed = cyc - onCyc;
    ticks = tickTotal - onTicks;
    upper = ((SCYC > SUS * tickP) ? SCYC : SUS * tickP) + tickP + 3;
    chk(elapsed >= SCYC + 1, "R9", "cycles before ready", elapsed, SCYC + 1);
    chk(ticks >= SUS, "R9", "ticks before ready", ticks, SUS);
    chk(elapsed <= upper, "R9", "ready not late", elapsed, upper);
    chk(logN == n, poke ? "R10" : "R7", "number of writes", logN, n);
    for (int k = 0; k < n && k < logN; k++) begin
      chk(logA[k] == eA[k], eT[k], $sformatf("write %0d address", k), logA[k], eA[k]);
      chk(logD[k] == eD[k], eT[k], $sformatf("write %0d data", k), logD[k], eD[k]);
    end
    chk(!busWr && !error, "R7", "bus idle when ready", {busWr, error}, 0);
  endtask

  task automatic t_timeout();
    int lim = 0;
    @(negedge clk);
    stall = 1'b1; logN = 0; bridgeStrap = 1'b0;
    pulseStart();
    while (!error && lim < 200) begin @(negedge clk); lim++; end
    chk(error, "R11", "error after stalled write", error, 1);
    chk(lim >= TO - 3, "R11", "error not early", lim, TO - 3);
    @(negedge clk);
    chk(!busWr && !ready && !descReq, "R11", "bus silent in fault",
        {busWr, ready, descReq}, 0);
    chk(logN == 0, "R11", "no write accepted", logN, 0);
    stall = 1'b0;
    repeat (3) @(negedge clk);
    chk(error, "R11", "error holds without start", error, 1);
  endtask

  initial begin
    t_reset();
    runSeq(1'b1, 1'b0, 0, 1, 1'b0);
    runSeq(1'b0, 1'b1, 2, 4, 1'b1);
    t_timeout();
    runSeq(1'b0, 1'b0, 1, 3, 1'b0);
    chk(!error, "R11", "error cleared by restart", error, 0);
    chk(stabErr == 0, "R5", "pending write stable", stabErr, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule